// File: doc/BRIEF.md
# Power-Down Request Persistence Filter

This block watches a level request from a function that wants to enter a low-power state and turns it into an interrupt request. The interrupt is raised only after the request has stayed high for a filter time chosen by a 3-bit code. The code can disable the request path, raise the interrupt at once, or pick one of three long waits of 4, 129 or 518 seconds. Time is counted in whole pulses of a one-second tick input that arrives from outside the block.

The block counts ticks only while the request stays high and the code does not change. If the request drops, the count starts again from zero and the interrupt falls. If the code changes, the count also starts again and then uses the new duration. Once raised, the interrupt holds until the request drops or the code changes.

All pins are plain levels or single-cycle pulses, and the block has no handshake. The tick is a one-cycle pulse. The interrupt output is a registered level.

Top module: `pwrdn_req_filter`

## Requirements
- R1: While reset is active and on the first edge after it, irq_o is low. The internal code register resets to the disabled code 000.
- R2: With code 000 held, irq_o never goes high, however long the request stays high and however many ticks arrive.
- R3: With code 001 held and the request held high, irq_o rises on the clock edge after the edge that takes the 4th tick. It is still low right after that 4th tick edge.
- R4: With code 010 held and the request held high, irq_o rises one edge after the 129th tick is taken, and not before.
- R5: With code 011 held and the request held high, irq_o rises one edge after the 518th tick is taken, and not before.
- R6: With any code whose bit 2 is 1 (100, 101, 110, 111) held stable, irq_o is high from the first clock edge that samples req_i high. No tick is needed.
- R7: Ticks that arrive while req_i is low are not counted. A drop of req_i to low on any edge clears the tick count, so the full delay is needed again afterwards.
- R8: On an edge that samples req_i low, irq_o is low after that edge.
- R9: A change of code_i clears the tick count. irq_o is low after the edge that sees the change, and the new code's full delay is then counted from zero.
- R10: Once high, irq_o stays high for as long as req_i stays high and code_i does not change, and further ticks do not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse marking one second |
| req_i | input | 1 | Power-down request level from the function |
| code_i | input | 3 | Filter code: 000 disabled, 001/010/011 timed, 1XX immediate |
| irq_o | output | 1 | Interrupt request level |

## Verification
The bench builds the block with its default delays of 4, 129 and 518 ticks, so every timed code is tested at its real count. It drives a tick every four clock cycles, which brings even the 518-tick wait within a few thousand cycles. That short tick spacing lets the bench check the exact edge on which each timed interrupt rises. It also lets it test a code change partway through a long count and a request drop just before expiry.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TIMED = 2'd1,
    MODE_NOW   = 2'd2
  } pdf_mode_e;

  localparam logic [2:0] CODE_OFF   = 3'b000;
  localparam logic [2:0] CODE_SHORT = 3'b001;
  localparam logic [2:0] CODE_MID   = 3'b010;
  localparam logic [2:0] CODE_LONG  = 3'b011;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pdf_code_track.sv
module pdf_code_track (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] code_i,
  output logic [2:0] code_q_o,
  output logic       chg_o
);
  logic [2:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= pdf_pkg::CODE_OFF;
    else         code_q <= code_i;
  end

  assign code_q_o = code_q;
  assign chg_o    = (code_i != code_q);
endmodule

// File: rtl/pdf_code_decode.sv
module pdf_code_decode #(
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned SHORT_TICKS = 4,
  parameter int unsigned MID_TICKS   = 129,
  parameter int unsigned LONG_TICKS  = 518
) (
  input  logic [2:0]          code_i,
  output pdf_pkg::pdf_mode_e  mode_o,
  output logic [CNT_W-1:0]    limit_o
);
  import pdf_pkg::*;

  always_comb begin
    mode_o  = MODE_OFF;
    limit_o = '0;
    if (code_i[2]) begin
      mode_o = MODE_NOW;
    end else begin
      unique case (code_i[1:0])
        2'b00: mode_o = MODE_OFF;
        2'b01: begin mode_o = MODE_TIMED; limit_o = CNT_W'(SHORT_TICKS); end
        2'b10: begin mode_o = MODE_TIMED; limit_o = CNT_W'(MID_TICKS);   end
        default: begin mode_o = MODE_TIMED; limit_o = CNT_W'(LONG_TICKS); end
      endcase
    end
  end
endmodule

// File: rtl/pdf_tick_count.sv
module pdf_tick_count #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (adv_i && cnt_q != limit_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign done_o = (cnt_q == limit_i);
endmodule

// File: rtl/pwrdn_req_filter.sv
module pwrdn_req_filter #(
  parameter int unsigned SHORT_TICKS = 4,
  parameter int unsigned MID_TICKS   = 129,
  parameter int unsigned LONG_TICKS  = 518
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       req_i,
  input  logic [2:0] code_i,
  output logic       irq_o
);
  import pdf_pkg::*;

  localparam int unsigned MAX_TICKS = max3(SHORT_TICKS, MID_TICKS, LONG_TICKS);
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  logic [2:0]       code_q;
  logic             code_chg;
  pdf_mode_e        mode;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q;
  logic             expired;
  logic             cnt_clr;
  logic             irq_d;
  logic             irq_q;

  pdf_code_track u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .code_i   (code_i),
    .code_q_o (code_q),
    .chg_o    (code_chg)
  );

  pdf_code_decode #(
    .CNT_W       (CNT_W),
    .SHORT_TICKS (SHORT_TICKS),
    .MID_TICKS   (MID_TICKS),
    .LONG_TICKS  (LONG_TICKS)
  ) u_decode (
    .code_i  (code_q),
    .mode_o  (mode),
    .limit_o (limit)
  );

  assign cnt_clr = !req_i || code_chg || (mode != MODE_TIMED);

  pdf_tick_count #(.CNT_W(CNT_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_clr),
    .adv_i   (tick_i),
    .limit_i (limit),
    .cnt_o   (cnt_q),
    .done_o  (expired)
  );

  always_comb begin
    irq_d = 1'b0;
    if (req_i && !code_chg) begin
      unique case (mode)
        MODE_NOW:   irq_d = 1'b1;
        MODE_TIMED: irq_d = expired;
        default:    irq_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pwrdn_req_filter_chk.sv
module pwrdn_req_filter_chk #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [2:0]       code_i,
  input logic             irq_o,
  input logic             code_chg,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] limit
);
  // R8
  drop_clears_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !irq_o);

  // R2
  off_code_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == 3'b000) |=> !irq_o);

  // R6
  now_code_fires_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && code_i[2] && !code_chg) |=> irq_o);

  // R9
  change_restarts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_chg |=> (cnt == '0) && !irq_o);

  // R7
  idle_count_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (cnt == '0));

  // R3
  count_bounded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= limit);
endmodule

bind pwrdn_req_filter pwrdn_req_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .code_i   (code_i),
  .irq_o    (irq_o),
  .code_chg (code_chg),
  .cnt      (cnt_q),
  .limit    (limit)
);

// File: tb/test_pwrdn_req_filter.sv
module test_pwrdn_req_filter;
  localparam time CLK_PERIOD = 10ns;
  localparam int  TICK_GAP   = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       req_i = 1'b0;
  logic [2:0] code_i = 3'b000;
  logic       irq_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrdn_req_filter i_pwrdn_req_filter (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .req_i  (req_i),
    .code_i (code_i),
    .irq_o  (irq_o)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic exp);
    n_checks++;
    if (irq_o !== exp) begin
      n_errors++;
      $display("FAIL %s: irq_o=%b expected=%b at %0t", req, irq_o, exp, $time);
    end
  endtask

  // n full tick periods: tick pulse then idle gap
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; step(); tick_i = 1'b0;
      repeat (TICK_GAP - 1) step();
    end
  endtask

  task automatic idle(input logic [2:0] code);
    req_i = 1'b0; code_i = code; step(); step();
  endtask

  // last tick taken precisely: low right after it, high one edge later
  task automatic last_tick(input string req);
    tick_i = 1'b1; step(); tick_i = 1'b0;
    check(req, 1'b0);
    step();
    check(req, 1'b1);
  endtask

  task automatic t_reset();
    req_i = 1'b1; code_i = 3'b000;
    check("R1", 1'b0);
    rst_ni = 1'b1; step();
    check("R1", 1'b0);
    idle(3'b000);
  endtask

  task automatic t_off();
    idle(3'b000); req_i = 1'b1; step();
    ticks(600);
    check("R2", 1'b0);
    idle(3'b000);
  endtask

  task automatic t_timed(input logic [2:0] code, input int n, input string req);
    idle(code); req_i = 1'b1; step();
    ticks(n - 1);
    check(req, 1'b0);
    last_tick(req);
    ticks(5);
    check("R10", 1'b1);
    idle(3'b000);
  endtask

  task automatic t_now();
    for (int c = 4; c < 8; c++) begin
      idle(3'(c));
      req_i = 1'b1; step();
      check("R6", 1'b1);
      req_i = 1'b0; step();
      check("R8", 1'b0);
    end
    idle(3'b000);
  endtask

  task automatic t_idle_ticks();
    idle(3'b001);
    ticks(10);
    req_i = 1'b1; step();
    ticks(3);
    check("R7", 1'b0);
    req_i = 1'b0; step(); req_i = 1'b1; step();
    ticks(3);
    check("R7", 1'b0);
    last_tick("R7");
    req_i = 1'b0; step();
    check("R8", 1'b0);
    idle(3'b000);
  endtask

  task automatic t_change();
    idle(3'b011); req_i = 1'b1; step();
    ticks(200);
    code_i = 3'b001; step();
    check("R9", 1'b0);
    ticks(3);
    check("R9", 1'b0);
    last_tick("R9");
    code_i = 3'b010; step();
    check("R9", 1'b0);
    idle(3'b000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_off();
    t_timed(3'b001, 4, "R3");
    t_timed(3'b010, 129, "R4");
    t_timed(3'b011, 518, "R5");
    t_now();
    t_idle_ticks();
    t_change();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    end
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule